// File: doc/BRIEF.md
# Oldest-First Deflection Port Allocator

This block assigns output ports in one router of a bufferless two-dimensional mesh. The router has no flit storage. Each cycle, up to four flits come in from the neighbour links, and every one of them must leave on some output. Each flit carries its destination coordinates and an age stamp. The allocator ranks the flits by age, oldest first. It then serves them in that order. A flit takes a free output that moves it toward its destination when one exists. When none is free, the flit is deflected onto any free mesh link.

A flit addressed to this node leaves through the local (ejection) port. One local flit may be injected after all arriving flits have been placed. It is accepted only if it can be placed. A mode input selects between two routing rules: single X-then-Y routing, or requesting every productive direction.

The allocation is computed from the current inputs. It is presented on registered outputs one clock later. The outputs report, for each output port, whether it carries a flit and which source the flit came from. They also report a per-link deflection flag and the result of the injection attempt.

Top module: `dfl_alloc`

## Requirements
- R1: Output index 0 is north (y+1), 1 is east (x+1), 2 is south (y-1), 3 is west (x-1) and 4 is local. Input link i carries the flit that arrived from the neighbour in direction i. out_src holds a 3-bit source per output: 0 to 3 for an input link, 4 for injection. All results appear on the registered outputs one clock after the inputs that caused them.
- R2: Every accepted arriving flit is assigned exactly one output in the same allocation. No output is given to two sources. An idle cycle leaves all outputs cleared.
- R3: Flits are served in order of age, and a larger age value means older. A flit gets a free productive output whenever one remains after the older flits have been placed. A flit that arrives alone is never deflected.
- R4: When two flits have equal age, the one on the lower input index is served first.
- R5: With cfg_mdr=0, a flit requests only east or west while its x differs from the node. It requests north or south only once x matches.
- R6: With cfg_mdr=1, a flit requests every productive direction. Among the free ones, the lowest output index is taken.
- R7: A flit with no free productive output is deflected to the lowest-index free on-mesh link. out_defl[i] is set for its input.
- R8: A flit whose destination equals the node takes the local port. If the local port is already taken, it is deflected as in R7.
- R9: An injected flit is placed after all arrivals. It takes a free productive output if there is one, and otherwise the lowest free on-mesh link. The local port counts only when the flit is addressed to this node. If none of these is free, inj_stall is raised instead of inj_grant.
- R10: At a mesh edge, outputs leading off the mesh are never driven. in_valid on a link facing off the mesh is ignored.
- R11: While reset is asserted, and for two clocks after its release, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mdr | input | 1 | 0: X-then-Y routing, 1: all productive directions |
| node_x | input | 3 | X coordinate of this node |
| node_y | input | 3 | Y coordinate of this node |
| in_valid | input | 4 | Flit present on link 0..3 |
| in_dst_x | input | 12 | Destination x, 3 bits per link |
| in_dst_y | input | 12 | Destination y, 3 bits per link |
| in_age | input | 32 | Age stamp, 8 bits per link |
| inj_valid | input | 1 | Local flit offered for injection |
| inj_dst_x | input | 3 | Destination x of the injected flit |
| inj_dst_y | input | 3 | Destination y of the injected flit |
| out_valid | output | 5 | Output port 0..4 carries a flit |
| out_src | output | 15 | Source index per output, 3 bits each |
| out_defl | output | 4 | Flit of link 0..3 was deflected |
| inj_grant | output | 1 | Injection accepted |
| inj_stall | output | 1 | Injection refused, no usable port |

## Verification
Every result of this block passes through one register stage. A flit pattern driven before a rising edge therefore shows up on out_valid, out_src, out_defl and the injection flags right after that edge. The bench applies each pattern at a falling edge, waits exactly one falling edge, and only then compares. In one scenario it also compares just before that edge, to confirm that nothing leaks through early. Reset release passes through two synchronising flops, so the bench waits three falling edges before its first stimulus.

// File: rtl/dfl_pkg.sv
package dfl_pkg;
  localparam int NLINK = 4;
  localparam int NPORT = 5;
  localparam int SRC_W = 3;

  typedef enum logic [2:0] {
    P_N = 3'd0,
    P_E = 3'd1,
    P_S = 3'd2,
    P_W = 3'd3,
    P_L = 3'd4
  } port_e;

  localparam logic [SRC_W-1:0] SRC_INJ = 3'd4;
  localparam logic [NPORT-1:0] MESH_MASK = 5'b01111;
endpackage

// File: rtl/dfl_route.sv
module dfl_route
  import dfl_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          mdr,
  input  logic [CW-1:0] cur_x,
  input  logic [CW-1:0] cur_y,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  output logic [NPORT-1:0] want
);
  logic x_go, y_go;

  always_comb begin
    x_go = (dst_x != cur_x);
    y_go = (dst_y != cur_y);
    want = '0;
    if (!x_go && !y_go) begin
      want[P_L] = 1'b1;
    end else if (mdr) begin
      want[P_E] = dst_x > cur_x;
      want[P_W] = dst_x < cur_x;
      want[P_N] = dst_y > cur_y;
      want[P_S] = dst_y < cur_y;
    end else if (x_go) begin
      want[P_E] = dst_x > cur_x;
      want[P_W] = dst_x < cur_x;
    end else begin
      want[P_N] = dst_y > cur_y;
      want[P_S] = dst_y < cur_y;
    end
  end
endmodule

// File: rtl/dfl_age_rank.sv
module dfl_age_rank #(
  parameter int N  = 4,
  parameter int AW = 8,
  localparam int RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    valid,
  input  logic [N*AW-1:0] age,
  output logic [N*RW-1:0] rank
);
  for (genvar gi = 0; gi < N; gi++) begin : g_rank
    int ahead;
    always_comb begin
      ahead = 0;
      for (int j = 0; j < N; j++) begin
        if (j != gi && valid[j]) begin
          if ((age[j*AW +: AW] > age[gi*AW +: AW]) ||
              ((age[j*AW +: AW] == age[gi*AW +: AW]) && (j < gi)))
            ahead = ahead + 1;
        end
      end
      rank[gi*RW +: RW] = RW'(ahead);
    end
  end
endmodule

// File: rtl/dfl_match.sv
module dfl_match
  import dfl_pkg::*;
#(
  parameter int N  = 4,
  localparam int RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       valid,
  input  logic [N*RW-1:0]    rank,
  input  logic [N*NPORT-1:0] want,
  input  logic [NLINK-1:0]   link_ok,
  input  logic               inj_valid,
  input  logic [NPORT-1:0]   inj_want,
  output logic [NPORT-1:0]   oval,
  output logic [NPORT*SRC_W-1:0] osrc,
  output logic [N-1:0]       defl,
  output logic               inj_ok,
  output logic               inj_stall
);
  function automatic logic [2:0] first_set(input logic [NPORT-1:0] m);
    logic [2:0] r;
    r = '0;
    for (int b = NPORT - 1; b >= 0; b--)
      if (m[b]) r = 3'(b);
    return r;
  endfunction

  logic [NPORT-1:0] freem;
  logic [NPORT-1:0] cand;
  logic [2:0]       p;

  always_comb begin
    freem     = {1'b1, link_ok};
    cand      = '0;
    p         = '0;
    oval      = '0;
    osrc      = '0;
    defl      = '0;
    inj_ok    = 1'b0;
    inj_stall = 1'b0;
    for (int k = 0; k < N; k++) begin
      for (int i = 0; i < N; i++) begin
        if (valid[i] && (rank[i*RW +: RW] == RW'(k))) begin
          cand = want[i*NPORT +: NPORT] & freem;
          if (cand != '0) begin
            p = first_set(cand);
          end else begin
            p = first_set(freem & MESH_MASK);
            defl[i] = 1'b1;
          end
          oval[p] = 1'b1;
          osrc[int'(p)*SRC_W +: SRC_W] = SRC_W'(i);
          freem[p] = 1'b0;
        end
      end
    end
    if (inj_valid) begin
      cand = inj_want & freem;
      if (cand == '0) cand = freem & MESH_MASK;
      if (cand != '0) begin
        p = first_set(cand);
        oval[p] = 1'b1;
        osrc[int'(p)*SRC_W +: SRC_W] = SRC_INJ;
        inj_ok = 1'b1;
      end else begin
        inj_stall = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dfl_alloc.sv
module dfl_alloc
  import dfl_pkg::*;
#(
  parameter int MESH_DIM = 8,
  parameter int AGE_W    = 8,
  localparam int CW      = $clog2(MESH_DIM)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_mdr,
  input  logic [CW-1:0]            node_x,
  input  logic [CW-1:0]            node_y,
  input  logic [NLINK-1:0]         in_valid,
  input  logic [NLINK*CW-1:0]      in_dst_x,
  input  logic [NLINK*CW-1:0]      in_dst_y,
  input  logic [NLINK*AGE_W-1:0]   in_age,
  input  logic                     inj_valid,
  input  logic [CW-1:0]            inj_dst_x,
  input  logic [CW-1:0]            inj_dst_y,
  output logic [NPORT-1:0]         out_valid,
  output logic [NPORT*SRC_W-1:0]   out_src,
  output logic [NLINK-1:0]         out_defl,
  output logic                     inj_grant,
  output logic                     inj_stall
);
  localparam int RW = $clog2(NLINK);
  localparam logic [CW-1:0] EDGE_HI = CW'(MESH_DIM - 1);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  // links that exist at this node
  logic [NLINK-1:0] link_ok;
  logic [NLINK-1:0] v_eff;
  always_comb begin
    link_ok[P_N] = node_y != EDGE_HI;
    link_ok[P_E] = node_x != EDGE_HI;
    link_ok[P_S] = node_y != '0;
    link_ok[P_W] = node_x != '0;
    v_eff        = in_valid & link_ok;
  end

  // productive directions per arriving flit and for injection
  logic [NLINK*NPORT-1:0] want;
  logic [NPORT-1:0]       inj_want;

  for (genvar gi = 0; gi < NLINK; gi++) begin : g_route
    dfl_route #(.CW(CW)) u_route (
      .mdr   (cfg_mdr),
      .cur_x (node_x),
      .cur_y (node_y),
      .dst_x (in_dst_x[gi*CW +: CW]),
      .dst_y (in_dst_y[gi*CW +: CW]),
      .want  (want[gi*NPORT +: NPORT])
    );
  end

  dfl_route #(.CW(CW)) u_route_inj (
    .mdr   (cfg_mdr),
    .cur_x (node_x),
    .cur_y (node_y),
    .dst_x (inj_dst_x),
    .dst_y (inj_dst_y),
    .want  (inj_want)
  );

  // age ordering ahead of the matching chain
  logic [NLINK*RW-1:0] rank;
  dfl_age_rank #(.N(NLINK), .AW(AGE_W)) u_rank (
    .valid (v_eff),
    .age   (in_age),
    .rank  (rank)
  );

  logic [NPORT-1:0]       oval_d;
  logic [NPORT*SRC_W-1:0] osrc_d;
  logic [NLINK-1:0]       defl_d;
  logic                   igrant_d, istall_d;

  dfl_match #(.N(NLINK)) u_match (
    .valid     (v_eff),
    .rank      (rank),
    .want      (want),
    .link_ok   (link_ok),
    .inj_valid (inj_valid),
    .inj_want  (inj_want),
    .oval      (oval_d),
    .osrc      (osrc_d),
    .defl      (defl_d),
    .inj_ok    (igrant_d),
    .inj_stall (istall_d)
  );

  // output stage: load on new work or to clear a busy result
  logic load_en;
  always_comb begin
    load_en = (|v_eff) | inj_valid | (|out_valid) | inj_grant | inj_stall;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      out_valid <= '0;
      out_src   <= '0;
      out_defl  <= '0;
      inj_grant <= 1'b0;
      inj_stall <= 1'b0;
    end else if (load_en) begin
      out_valid <= oval_d;
      out_src   <= osrc_d;
      out_defl  <= defl_d;
      inj_grant <= igrant_d;
      inj_stall <= istall_d;
    end
  end
endmodule

// File: rtl/dfl_alloc_chk.sv
module dfl_alloc_chk
  import dfl_pkg::*;
(
  input logic                   clk,
  input logic                   rst_ok,
  input logic [NLINK-1:0]       v_eff,
  input logic [NLINK-1:0]       link_ok,
  input logic                   inj_valid,
  input logic [NPORT-1:0]       out_valid,
  input logic [NPORT*SRC_W-1:0] out_src,
  input logic [NLINK-1:0]       out_defl,
  input logic                   inj_grant,
  input logic                   inj_stall
);
  logic armed;
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R2: one output per accepted flit, plus one for a granted injection
  a_r2_complete: assert property (@(posedge clk) disable iff (!rst_ok)
    armed |-> ($countones(out_valid) ==
               $countones($past(v_eff)) + (inj_grant ? 1 : 0)));

  // R2: no two driven outputs name the same source
  for (genvar ga = 0; ga < NPORT; ga++) begin : g_pa
    for (genvar gb = ga + 1; gb < NPORT; gb++) begin : g_pb
      a_r2_distinct: assert property (@(posedge clk) disable iff (!rst_ok)
        (out_valid[ga] && out_valid[gb]) |->
        (out_src[ga*SRC_W +: SRC_W] != out_src[gb*SRC_W +: SRC_W]));
    end
  end

  // R3: a lone arriving flit is never deflected
  a_r3_lone_flit: assert property (@(posedge clk) disable iff (!rst_ok)
    (armed && $past($countones(v_eff) == 1)) |-> (out_defl == '0));

  // R7: deflection flags only for flits that were accepted
  a_r7_defl_valid: assert property (@(posedge clk) disable iff (!rst_ok)
    armed |-> ((out_defl & ~$past(v_eff)) == '0));

  // R9: grant and stall exclusive, and only after an offer
  a_r9_inj_excl: assert property (@(posedge clk) disable iff (!rst_ok)
    !(inj_grant && inj_stall));
  a_r9_inj_cause: assert property (@(posedge clk) disable iff (!rst_ok)
    (armed && (inj_grant || inj_stall)) |-> $past(inj_valid));

  // R10: no output off the mesh edge
  a_r10_edge: assert property (@(posedge clk) disable iff (!rst_ok)
    armed |-> ((out_valid[NLINK-1:0] & ~$past(link_ok)) == '0));

  // R11: quiet while held in reset
  always @(negedge clk) begin
    if (!rst_ok) begin
      a_r11_reset_quiet: assert (out_valid == '0 && out_defl == '0 &&
                                 !inj_grant && !inj_stall);
    end
  end
endmodule

bind dfl_alloc dfl_alloc_chk u_chk (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .v_eff     (v_eff),
  .link_ok   (link_ok),
  .inj_valid (inj_valid),
  .out_valid (out_valid),
  .out_src   (out_src),
  .out_defl  (out_defl),
  .inj_grant (inj_grant),
  .inj_stall (inj_stall)
);

// File: tb/dfl_alloc_test.sv
module dfl_alloc_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_mdr;
  logic [2:0]  node_x, node_y;
  logic [3:0]  in_valid;
  logic [11:0] in_dst_x, in_dst_y;
  logic [31:0] in_age;
  logic        inj_valid;
  logic [2:0]  inj_dst_x, inj_dst_y;
  logic [4:0]  out_valid;
  logic [14:0] out_src;
  logic [3:0]  out_defl;
  logic        inj_grant, inj_stall;

  always #10 clk = ~clk;

  dfl_alloc uut (
    .clk(clk), .rst_n(rst_n), .cfg_mdr(cfg_mdr),
    .node_x(node_x), .node_y(node_y),
    .in_valid(in_valid), .in_dst_x(in_dst_x), .in_dst_y(in_dst_y),
    .in_age(in_age), .inj_valid(inj_valid),
    .inj_dst_x(inj_dst_x), .inj_dst_y(inj_dst_y),
    .out_valid(out_valid), .out_src(out_src), .out_defl(out_defl),
    .inj_grant(inj_grant), .inj_stall(inj_stall)
  );

  int  n_run  = 0;
  int  n_fail = 0;
  bit  closed = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] src_of(input int p);
    return 32'(out_src[p*3 +: 3]);
  endfunction

  task automatic clear_in();
    in_valid  = '0; in_dst_x = '0; in_dst_y = '0; in_age = '0;
    inj_valid = 1'b0; inj_dst_x = '0; inj_dst_y = '0;
  endtask

  task automatic put(input int i, input int x, input int y, input int a);
    in_valid[i]        = 1'b1;
    in_dst_x[i*3 +: 3] = 3'(x);
    in_dst_y[i*3 +: 3] = 3'(y);
    in_age[i*8 +: 8]   = 8'(a);
  endtask

  task automatic at_node(input int x, input int y, input logic mdr);
    node_x = 3'(x); node_y = 3'(y); cfg_mdr = mdr;
  endtask

  // inputs set at a falling edge; registered result sampled at the next one
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    clear_in(); at_node(3, 3, 1'b0);
    put(1, 6, 3, 5);
    repeat (3) tick();
    chk("R11", "out_valid in reset", 32'(out_valid), 0);
    chk("R11", "inj flags in reset", 32'({inj_grant, inj_stall}), 0);
    rst_n = 1'b1;
    tick();
    chk("R11", "out_valid during release", 32'(out_valid), 0);
    clear_in();
    repeat (3) tick();
  endtask

  task automatic t_single_dor();
    clear_in(); at_node(3, 3, 1'b0);
    put(3, 5, 3, 1);
    #1 chk("R1", "no early result", 32'(out_valid), 0);
    tick();
    chk("R1", "east valid", 32'(out_valid), 32'b00010);
    chk("R1", "east source", src_of(1), 3);
    chk("R3", "lone flit defl", 32'(out_defl), 0);
    clear_in(); tick();
    chk("R2", "idle clears", 32'(out_valid), 0);
  endtask

  task automatic t_age_wins();
    clear_in(); at_node(3, 3, 1'b0);
    put(0, 6, 3, 10); put(2, 6, 3, 20);
    tick();
    chk("R3", "older takes east", src_of(1), 2);
    chk("R7", "loser to north", src_of(0), 0);
    chk("R7", "defl flags", 32'(out_defl), 32'b0001);
    chk("R2", "two outputs", 32'(out_valid), 32'b00011);
    clear_in(); at_node(3, 3, 1'b0);
    put(0, 7, 3, 1); put(3, 7, 3, 200);
    tick();
    chk("R3", "age beats index", src_of(1), 3);
    chk("R7", "index 0 deflected", 32'(out_defl), 32'b0001);
  endtask

  task automatic t_tie();
    clear_in(); at_node(3, 3, 1'b0);
    put(1, 3, 6, 5); put(3, 3, 6, 5);
    tick();
    chk("R4", "tie lower index north", src_of(0), 1);
    chk("R4", "tie loser east", src_of(1), 3);
    chk("R4", "tie defl", 32'(out_defl), 32'b1000);
  endtask

  task automatic t_modes();
    clear_in(); at_node(3, 3, 1'b0);
    put(0, 7, 3, 30); put(2, 5, 6, 1);
    tick();
    chk("R5", "dor defl of diagonal", 32'(out_defl), 32'b0100);
    chk("R5", "dor north src", src_of(0), 2);
    clear_in(); at_node(3, 3, 1'b1);
    put(0, 7, 3, 30); put(2, 5, 6, 1);
    tick();
    chk("R6", "mdr no defl", 32'(out_defl), 0);
    chk("R6", "mdr north src", src_of(0), 2);
    clear_in(); at_node(3, 3, 1'b0);
    put(1, 5, 6, 4);
    tick();
    chk("R5", "dor single x first", 32'(out_valid), 32'b00010);
    clear_in(); at_node(3, 3, 1'b1);
    put(1, 5, 6, 4);
    tick();
    chk("R6", "mdr lowest productive", 32'(out_valid), 32'b00001);
  endtask

  task automatic t_eject();
    clear_in(); at_node(3, 3, 1'b0);
    put(0, 3, 3, 9); put(1, 3, 3, 3);
    tick();
    chk("R8", "older ejects", src_of(4), 0);
    chk("R8", "younger to north", src_of(0), 1);
    chk("R8", "valid", 32'(out_valid), 32'b10001);
    chk("R8", "defl", 32'(out_defl), 32'b0010);
  endtask

  task automatic t_inject();
    clear_in(); at_node(3, 3, 1'b0);
    put(1, 3, 6, 5);
    inj_valid = 1'b1; inj_dst_x = 3'd3; inj_dst_y = 3'd0;
    tick();
    chk("R9", "inject productive south", src_of(2), 4);
    chk("R9", "grant", 32'({inj_grant, inj_stall}), 32'b10);
    clear_in(); at_node(3, 3, 1'b0);
    put(0, 3, 0, 7);
    inj_valid = 1'b1; inj_dst_x = 3'd3; inj_dst_y = 3'd0;
    tick();
    chk("R9", "inject deflected north", src_of(0), 4);
    chk("R9", "arrival keeps south", src_of(2), 0);
    clear_in(); at_node(3, 3, 1'b0);
    put(0, 7, 3, 4); put(1, 7, 3, 3); put(2, 7, 3, 2); put(3, 7, 3, 1);
    inj_valid = 1'b1; inj_dst_x = 3'd0; inj_dst_y = 3'd0;
    tick();
    chk("R9", "full stall flags", 32'({inj_grant, inj_stall}), 32'b01);
    chk("R2", "four mesh outputs", 32'(out_valid), 32'b01111);
    chk("R7", "three deflected", 32'(out_defl), 32'b1110);
    chk("R7", "west from link 3", src_of(3), 3);
    inj_dst_x = 3'd3; inj_dst_y = 3'd3;
    tick();
    chk("R9", "self inject to local", src_of(4), 4);
    chk("R9", "self inject grant", 32'({inj_grant, inj_stall}), 32'b10);
    clear_in(); tick();
    chk("R9", "flags clear when idle", 32'({inj_grant, inj_stall}), 0);
  endtask

  task automatic t_edges();
    clear_in(); at_node(0, 0, 1'b0);
    put(0, 0, 5, 2); put(1, 0, 5, 7);
    put(2, 0, 5, 255); put(3, 0, 5, 255);
    tick();
    chk("R10", "off-mesh links ignored", 32'(out_valid), 32'b00011);
    chk("R10", "older on-mesh takes north", src_of(0), 1);
    chk("R10", "loser to east", src_of(1), 0);
    chk("R10", "no defl on ignored", 32'(out_defl), 32'b0001);
    clear_in(); at_node(7, 7, 1'b0);
    put(2, 7, 7, 4); put(3, 7, 7, 9);
    tick();
    chk("R10", "corner outputs", 32'(out_valid), 32'b10100);
    chk("R8", "corner eject", src_of(4), 3);
    chk("R10", "skip off-mesh north", src_of(2), 2);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!closed) begin
      closed = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single_dor();
    t_age_wins();
    t_tie();
    t_modes();
    t_eject();
    t_inject();
    t_edges();
    if (!closed) begin
      closed = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule